// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Reload Strobe

This block is a watchdog timer. Software reaches it through a 64-bit single-cycle read/write strobe interface. Two addresses are decoded from a 20-bit offset: a control word and a reload ("kick") location. A fixed divide-by-1024 prescaler paces a 24-bit down-counter. Software sets only the upper 16 bits of each reload value. A write of any data to the kick location restarts the countdown from that reload value.

When the count runs out, the block raises a level interrupt, a one-cycle system-reset request, or both, according to a two-bit mode. Mode 1 raises the interrupt once and then parks. Mode 2 raises the interrupt and keeps reloading. Mode 3 raises the interrupt on the first expiry. If no kick or control write follows before the second expiry, it then issues a reset request. A control write of all zeros turns the timer off. A control write can also preload the live count directly, in the same write that sets the length and the mode.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset, `irq_o` and `rst_req_o` are low and a read of the control word returns zero.
- R2: The control word sits at offset 0x40000. Its fields are:
  - mode in bits [1:0];
  - reload length in bits [19:4];
  - live count in bits [43:20].

  A write loads all three fields. A read returns their current values, and every other bit reads as zero.
- R3: While the mode is nonzero, the count steps once per 1024 clocks. The first step lands exactly 1024 cycles after the most recent control write or kick.
- R4: A write to offset 0x50000, with any data, sets the count to {length, 8'h00}. It also clears `irq_o` and restarts the prescaler. A read of 0x50000 returns zero.
- R5: An expiry is a prescaler step taken while the count is 1 or 0. `irq_o` rises on the clock edge of the expiry. It then stays high until the next kick or control write.
- R6: In mode 1, the count parks at zero after an expiry and `rst_req_o` never rises.
- R7: In mode 2, each expiry reloads the count with {length, 8'h00}, sets the interrupt and never requests a reset.
- R8: In mode 3, the first expiry reloads the count and sets the interrupt. A second expiry with no kick or control write in between drives `rst_req_o` high for exactly one cycle.
- R9: In mode 0 the count is frozen and neither output rises. A control write of zero clears a pending interrupt.
- R10: Writes to any other offset change nothing, and reads of any other offset return zero.
- R11: Read data is registered. It appears in the cycle after `rd_en` and shows the state at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 20 | Byte offset within the block |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |
| irq_o | output | 1 | Expiry interrupt level |
| rst_req_o | output | 1 | One-cycle system-reset request |

## Verification
Assertions in the RTL check several properties on every cycle:
- prescaler steps are never back to back;
- the count decrements by exactly one per step;
- the count is frozen in mode 0;
- a kick always drops the interrupt on the next cycle;
- a reset request is only ever one cycle wide, happens only in mode 3, and only with the interrupt already set;
- reads of unmapped offsets return zero.

The bench scenarios cover the timing that assertions cannot see. They measure the exact 1024-cycle spacing of steps after a write or kick, and the cycle in which each mode's expiry arrives. They check the two-stage escalation of mode 3 and its cancellation by a kick. They also check the field layout and masking on read-back, and that writes to unmapped offsets leave the state unchanged.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF        = 2'd0,
    WD_IRQ_PARK   = 2'd1,
    WD_IRQ_RELOAD = 2'd2,
    WD_TWO_STAGE  = 2'd3
  } wd_mode_e;
endpackage

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int PRESC_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  logic [PRESC_W-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)   pcnt_q <= '0;
    else if (run)     pcnt_q <= pcnt_q + 1'b1;
  end

  // one step per full wrap of the divider
  assign tick = run && (&pcnt_q) && !clr;

  // R3: steps are isolated, never on consecutive cycles
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  wd_mode_e         mode,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] ctrl_cnt,
  input  logic             kick,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int FRAC_W = CNT_W - LEN_W;

  logic [CNT_W-1:0] reload;
  logic             at_end;

  assign reload = {len, {FRAC_W{1'b0}}};
  assign at_end = (count <= CNT_W'(1));
  assign expire = tick && (mode != WD_OFF) && at_end && !ctrl_wr && !kick;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (ctrl_wr) begin
      count <= ctrl_cnt;
    end else if (kick) begin
      count <= reload;
    end else if (tick && mode != WD_OFF) begin
      if (at_end) count <= (mode == WD_IRQ_PARK) ? '0 : reload;
      else        count <= count - 1'b1;
    end
  end

  // R9: frozen while off unless software loads it
  p_frozen_off_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == WD_OFF && !ctrl_wr && !kick) |=> $stable(count));
  // R3: a step away from the end removes exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && mode != WD_OFF && !ctrl_wr && !kick && count > CNT_W'(1))
      |=> count == $past(count) - 1'b1);
  // R6: parked mode settles at zero after expiry
  p_park_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && mode == WD_IRQ_PARK) |=> count == '0);
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wd_mode_e mode,
  input  logic     clr,
  input  logic     expire,
  output logic     irq,
  output logic     rst_req
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (clr) begin
        irq     <= 1'b0;
        armed_q <= 1'b0;
      end else if (expire) begin
        irq <= 1'b1;
        if (mode == WD_TWO_STAGE) begin
          armed_q <= 1'b1;
          if (armed_q) rst_req <= 1'b1;
        end
      end
    end
  end

  // R8: reset request is a single-cycle pulse
  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R8: escalation only follows an interrupt already raised
  p_rst_after_irq_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> irq);
  // R7: only the two-stage mode may request a reset
  p_rst_mode_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> mode == WD_TWO_STAGE);
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int              DATA_W   = 64,
  parameter int              ADDR_W   = 20,
  parameter int              PRESC_W  = 10,
  parameter int              LEN_W    = 16,
  parameter int              CNT_W    = 24,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 20'h40000,
  parameter logic [ADDR_W-1:0] KICK_OFS = 20'h50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int MODE_W  = 2;
  localparam int LEN_LSB = 4;
  localparam int CNT_LSB = LEN_LSB + LEN_W;

  wd_mode_e         mode_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] count;
  logic             ctrl_sel, kick_sel, ctrl_wr, kick_wr;
  logic             tick, expire;
  logic [DATA_W-1:0] ctrl_view;

  assign ctrl_sel = (addr == CTRL_OFS);
  assign kick_sel = (addr == KICK_OFS);
  assign ctrl_wr  = wr_en && ctrl_sel;
  assign kick_wr  = wr_en && kick_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= WD_OFF;
      len_q  <= '0;
    end else if (ctrl_wr) begin
      mode_q <= wd_mode_e'(wdata[MODE_W-1:0]);
      len_q  <= wdata[LEN_LSB +: LEN_W];
    end
  end

  wdog_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk (clk),
    .rst (rst),
    .run (mode_q != WD_OFF),
    .clr (ctrl_wr || kick_wr),
    .tick(tick)
  );

  wdog_count #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .ctrl_wr (ctrl_wr),
    .ctrl_cnt(wdata[CNT_LSB +: CNT_W]),
    .kick    (kick_wr),
    .len     (len_q),
    .tick    (tick),
    .count   (count),
    .expire  (expire)
  );

  wdog_expiry u_expiry (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_q),
    .clr    (ctrl_wr || kick_wr),
    .expire (expire),
    .irq    (irq_o),
    .rst_req(rst_req_o)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[MODE_W-1:0]         = mode_q;
    ctrl_view[LEN_LSB +: LEN_W]   = len_q;
    ctrl_view[CNT_LSB +: CNT_W]   = count;
  end

  always_ff @(posedge clk) begin
    if (rst)                   rdata <= '0;
    else if (rd_en && ctrl_sel) rdata <= ctrl_view;
    else                       rdata <= '0;
  end

  // R4: a kick always drops the interrupt
  p_kick_clears_r4: assert property (@(posedge clk) disable iff (rst)
    kick_wr |=> !irq_o);
  // R10: unmapped reads return zero
  p_rd_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !ctrl_sel) |=> rdata == '0);
  // R9: nothing fires while switched off
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == WD_OFF && !ctrl_wr) |=> !rst_req_o);
endmodule

// File: tb/sim_wdog_prescaled.sv
module sim_wdog_prescaled;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] A_CTRL = 20'h40000;
  localparam logic [19:0] A_KICK = 20'h50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [19:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq_o, rst_req_o;

  int n_chk = 0, n_bad = 0, pulses = 0;
  logic done = 1'b0;

  wdog_prescaled u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (!rst && rst_req_o) pulses++;

  function automatic logic [63:0] ctl(input logic [1:0] m, input logic [15:0] l,
                                      input logic [23:0] c);
    return {20'h0, c, l, 2'b00, m};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [19:0] a, input logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [63:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R1 irq", 64'(irq_o), 0);
    check("R1 rst_req", 64'(rst_req_o), 0);
    rd(A_CTRL, d);
    check("R1 ctrl", d, 0);
  endtask

  task automatic t_layout_and_prescale;
    logic [63:0] d;
    wr(A_CTRL, {20'hFFFFF, 24'h000003, 16'h1234, 2'b11, 2'b01});
    rd(A_CTRL, d);                        // captured at E0+1
    check("R2 R11 readback", d, ctl(2'd1, 16'h1234, 24'd3));
    idle(1022);
    rd(A_CTRL, d);                        // E0+1024, pre-step value
    check("R3 before step", d[43:20], 3);
    rd(A_CTRL, d);                        // E0+1025
    check("R3 after step", d[43:20], 2);
    idle(2046);
    check("R5 irq before expiry", 64'(irq_o), 0);
    idle(1);
    check("R5 irq at expiry", 64'(irq_o), 1);
    idle(2000);
    check("R5 irq held", 64'(irq_o), 1);
    check("R6 no reset", 64'(pulses), 0);
    rd(A_CTRL, d);
    check("R6 parked count", d[43:20], 0);
  endtask

  task automatic t_kick;
    logic [63:0] d;
    wr(A_KICK, 64'hDEAD_BEEF_0000_0001);
    check("R4 irq cleared", 64'(irq_o), 0);
    rd(A_CTRL, d);
    check("R4 reload value", d[43:20], 24'h123400);
    rd(A_KICK, d);
    check("R4 kick reads zero", d, 0);
  endtask

  task automatic t_two_stage;
    int base;
    base = pulses;
    wr(A_CTRL, ctl(2'd3, 16'h0, 24'd2));
    idle(2047);
    check("R8 irq before first", 64'(irq_o), 0);
    idle(1);
    check("R8 irq first expiry", 64'(irq_o), 1);
    idle(1023);
    check("R8 no reset yet", 64'(rst_req_o), 0);
    idle(1);
    check("R8 reset pulse", 64'(rst_req_o), 1);
    idle(1);
    check("R8 pulse one cycle", 64'(rst_req_o), 0);
    check("R8 pulse count", 64'(pulses - base), 1);
  endtask

  task automatic t_kick_cancels;
    int base;
    wr(A_CTRL, ctl(2'd3, 16'h0, 24'd1));
    idle(1024);
    check("R8 first expiry", 64'(irq_o), 1);
    base = pulses;
    wr(A_KICK, 64'h0);
    check("R4 kick clears", 64'(irq_o), 0);
    idle(1023);
    check("R3 kick restarts prescaler", 64'(irq_o), 0);
    idle(1);
    check("R8 kick cancels escalation irq", 64'(irq_o), 1);
    check("R8 kick cancels escalation rst", 64'(pulses - base), 0);
  endtask

  task automatic t_reload_mode;
    logic [63:0] d;
    int base;
    base = pulses;
    wr(A_CTRL, ctl(2'd2, 16'h0003, 24'd1));
    idle(1023);
    rd(A_CTRL, d);                        // captured at E0+1024
    check("R7 before expiry", d[43:20], 1);
    rd(A_CTRL, d);
    check("R7 reload after expiry", d[43:20], 24'h000300);
    check("R7 irq", 64'(irq_o), 1);
    idle(3000);
    check("R7 no reset", 64'(pulses - base), 0);
  endtask

  task automatic t_off;
    logic [63:0] d;
    int base;
    wr(A_CTRL, ctl(2'd3, 16'h0, 24'd1));
    idle(1024);
    check("R9 setup irq", 64'(irq_o), 1);
    base = pulses;
    wr(A_CTRL, 64'h0);
    check("R9 zero write clears irq", 64'(irq_o), 0);
    idle(3000);
    check("R9 off irq", 64'(irq_o), 0);
    check("R9 off no reset", 64'(pulses - base), 0);
    wr(A_CTRL, ctl(2'd0, 16'h0007, 24'd5));
    idle(3000);
    rd(A_CTRL, d);
    check("R9 frozen count", d, ctl(2'd0, 16'h0007, 24'd5));
  endtask

  task automatic t_unmapped;
    logic [63:0] d;
    wr(20'h00010, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_CTRL, d);
    check("R10 write ignored", d, ctl(2'd0, 16'h0007, 24'd5));
    rd(20'h00010, d);
    check("R10 read zero", d, 0);
  endtask

  task automatic t_restart;
    wr(A_CTRL, ctl(2'd1, 16'h0, 24'd2));
    idle(500);
    wr(A_CTRL, ctl(2'd1, 16'h0, 24'd2));
    idle(2047);
    check("R3 control write restarts prescaler", 64'(irq_o), 0);
    idle(1);
    check("R3 expiry after restart", 64'(irq_o), 1);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout_and_prescale();
    t_kick();
    t_two_stage();
    t_kick_cancels();
    t_reload_mode();
    t_off();
    t_unmapped();
    t_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule